// File: doc/BRIEF.md
# Buffered SPI Client Controller

This block is the receive/transmit engine of an SPI client that runs in mode 0 (data sampled on the rising SCK edge, changed on the falling edge, most significant bit first). Outgoing data is never written straight into the shift register. A host write lands in a single transmit holding register, and the shifter picks that byte up only at a byte boundary. Incoming bytes go into a small receive FIFO that the host drains with a read strobe. SCK, MOSI and the active-low select are brought into the system clock domain through flip-flop synchronizers and sampled there. For that reason SCK must run at no more than a quarter of the system clock.

A mode input picks how the first byte of a selected burst is sourced. With the mode low, the shifter already holds a byte when select falls, so that stale value goes out first as a dummy, and buffered data follows from the second byte. With the mode high, a byte written while select is inactive is copied into the shifter on the following clock, so user data is sent from the first edge. Three status outputs rise in a fixed, staggered order at each byte boundary: holding register empty, then receive data available, then transfer complete.

Top module: `spi_bufclient`

## Requirements
- R1: After reset, buf_empty is 1, rx_ready is 0, xfer_done is 0 and miso is 0.
- R2: A wr_en pulse while buf_empty is 1 stores wr_data in the holding register, and buf_empty reads 0 from the next cycle on. With wait_rx low, the write does not change the byte currently in the shifter.
- R3: A wr_en pulse while buf_empty is 0 is ignored, and its byte is never transmitted.
- R4: With wait_rx low, the first byte shifted out after select is the shifter's existing content (all zeros after reset). A held byte moves into the shifter at the end of a byte, and buf_empty rises on the cycle after that boundary.
- R5: With wait_rx high and ss_n high, a byte written while the shifter holds no unsent user data is copied into the shifter on the next cycle, so buf_empty reads 1 again. That byte is the first one sent once ss_n goes low, and later writes wait in the holding register.
- R6: When the holding register is empty at a byte boundary, the shifter sends the same byte again.
- R7: While selected, miso presents the shifter bits MSB first, changing after falling SCK edges, and MOSI is captured on rising edges. miso is 0 while ss_n is high.
- R8: Received bytes enter a FIFO of RX_DEPTH entries (2 by default). rd_data shows the oldest entry, and rd_en removes it. rx_ready is 1 while the FIFO holds data. A byte that arrives when the FIFO is full is dropped, and rd_en on an empty FIFO has no effect.
- R9: rx_ready is 1 two cycles after a byte boundary, which is one cycle after buf_empty rises for a handover at that boundary.
- R10: xfer_done rises one cycle after rx_ready, only for a boundary at which the holding register was empty. A boundary that loads a held byte does not set it.
- R11: A clr_done pulse or any wr_en pulse clears xfer_done on the next cycle, unless it is being set on that same cycle.
- R12: Raising ss_n in the middle of a byte discards the partial byte and restarts bit counting, so the next selected burst receives complete bytes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wait_rx | input | 1 | First-byte mode: 1 loads a byte written while deselected into the shifter |
| wr_en | input | 1 | Host data write strobe |
| wr_data | input | DATA_W | Byte to transmit |
| rd_en | input | 1 | Host read strobe, pops the oldest received byte |
| rd_data | output | DATA_W | Oldest received byte |
| clr_done | input | 1 | Clears the transfer-complete flag |
| buf_empty | output | 1 | Holding register can accept a write |
| rx_ready | output | 1 | Receive FIFO holds at least one byte |
| xfer_done | output | 1 | All supplied transmit data has been sent |
| sck | input | 1 | Serial clock from the host |
| mosi | input | 1 | Serial data from the host |
| ss_n | input | 1 | Active-low client select |
| miso | output | 1 | Serial data to the host |

## Verification
Some rules are checked on every cycle. A write to an empty holding register makes it full. A full holding register drains only at a byte boundary while selected. The two flags after a boundary rise in fixed order, with rx_ready present two cycles later and xfer_done rising only when rx_ready was high the cycle before. A clear or a write removes xfer_done, and a read of an empty FIFO leaves it empty. Other behaviour shows only in bench scenarios: which byte value actually leaves on MISO (the dummy byte, the discarded write, the repeated byte, the early copy in wait_rx mode), the order and loss of received bytes in the FIFO, and the recovery after a partial byte.

// File: rtl/spi_bufclient_pkg.sv
package spi_bufclient_pkg;
   localparam int unsigned SPI_BYTE_W = 8;

   // serial pins as seen by the synchronizer, packed as one vector
   typedef struct packed {
      logic sck;
      logic mosi;
      logic ss_n;
   } spi_pins_t;

   localparam spi_pins_t PINS_IDLE = '{sck: 1'b0, mosi: 1'b0, ss_n: 1'b1};
endpackage

// File: rtl/spi_bc_sync.sv
module spi_bc_sync #(
   parameter int unsigned W = 1,
   parameter int unsigned STAGES = 2,
   parameter logic [W-1:0] RST_VAL = '0
)(
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] d,
   output logic [W-1:0] q
);
   generate
      if (STAGES < 2) begin : g_bad_stages
         $error("spi_bc_sync: STAGES must be at least 2");
      end
   endgenerate

   logic [STAGES-1:0][W-1:0] chain;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) chain <= {STAGES{RST_VAL}};
      else        chain <= {chain[STAGES-2:0], d};
   end

   assign q = chain[STAGES-1];
endmodule

// File: rtl/spi_bc_serdes.sv
module spi_bc_serdes #(
   parameter int unsigned DATA_W = 8,
   parameter logic [DATA_W-1:0] SHIFT_INIT = '0
)(
   input  logic              clk,
   input  logic              rst_n,
   input  logic              sck_s,
   input  logic              mosi_s,
   input  logic              ss_act,
   input  logic              load_en,
   input  logic [DATA_W-1:0] load_val,
   output logic              miso,
   output logic              byte_done,
   output logic [DATA_W-1:0] rx_byte
);
   localparam int unsigned CW = (DATA_W > 2) ? $clog2(DATA_W) : 1;
   localparam logic [CW-1:0] LAST_BIT = CW'(DATA_W - 1);

   logic              sck_q;
   logic [CW-1:0]     bit_cnt;
   logic [DATA_W-1:0] tx_sh;
   logic [DATA_W-1:0] rx_sh;
   logic              sck_rise, sck_fall;

   assign sck_rise  = sck_s & ~sck_q;
   assign sck_fall  = ~sck_s & sck_q;
   assign byte_done = ss_act & sck_rise & (bit_cnt == LAST_BIT);
   assign rx_byte   = {rx_sh[DATA_W-2:0], mosi_s};
   assign miso      = ss_act & tx_sh[DATA_W-1];

   function automatic logic [DATA_W-1:0] rotl(input logic [DATA_W-1:0] v);
      return {v[DATA_W-2:0], v[DATA_W-1]};
   endfunction

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) sck_q <= 1'b0;
      else        sck_q <= sck_s;
   end

   // bit position inside the current byte; select loss restarts it
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                bit_cnt <= '0;
      else if (!ss_act)          bit_cnt <= '0;
      else if (sck_rise)         bit_cnt <= (bit_cnt == LAST_BIT) ? '0 : bit_cnt + 1'b1;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                rx_sh <= '0;
      else if (ss_act && sck_rise) rx_sh <= rx_byte;
   end

   // transmit shifter rotates so that an unreloaded byte comes round whole:
   // DATA_W-1 rotations on falling edges inside the byte, one at the boundary
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                                  tx_sh <= SHIFT_INIT;
      else if (load_en)                            tx_sh <= load_val;
      else if (byte_done)                          tx_sh <= rotl(tx_sh);
      else if (ss_act && sck_fall && bit_cnt != '0) tx_sh <= rotl(tx_sh);
   end
endmodule

// File: rtl/spi_bc_rxfifo.sv
module spi_bc_rxfifo #(
   parameter int unsigned DATA_W = 8,
   parameter int unsigned DEPTH  = 2
)(
   input  logic              clk,
   input  logic              rst_n,
   input  logic              push,
   input  logic [DATA_W-1:0] push_data,
   input  logic              pop,
   output logic [DATA_W-1:0] head,
   output logic              not_empty
);
   generate
      if (DEPTH == 0 || (DEPTH & (DEPTH - 1)) != 0) begin : g_bad_depth
         $error("spi_bc_rxfifo: DEPTH must be a power of two");
      end

      if (DEPTH == 1) begin : g_single
         logic [DATA_W-1:0] slot;
         logic              valid;
         logic              take;

         assign take = push & (~valid | pop);

         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)    valid <= 1'b0;
            else if (take) valid <= 1'b1;
            else if (pop)  valid <= 1'b0;
         end

         always_ff @(posedge clk) begin
            if (take) slot <= push_data;
         end

         assign head      = slot;
         assign not_empty = valid;
      end else begin : g_ring
         localparam int unsigned AW = $clog2(DEPTH);
         localparam logic [AW:0] FULL_CNT = (AW + 1)'(DEPTH);

         logic [DEPTH-1:0][DATA_W-1:0] mem;
         logic [AW-1:0] wptr, rptr;
         logic [AW:0]   cnt;
         logic          do_pop, do_push;

         assign do_pop  = pop & (cnt != '0);
         assign do_push = push & ((cnt != FULL_CNT) | do_pop);

         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               wptr <= '0;
               rptr <= '0;
               cnt  <= '0;
            end else begin
               if (do_push) wptr <= wptr + 1'b1;
               if (do_pop)  rptr <= rptr + 1'b1;
               case ({do_push, do_pop})
                  2'b10:   cnt <= cnt + 1'b1;
                  2'b01:   cnt <= cnt - 1'b1;
                  default: cnt <= cnt;
               endcase
            end
         end

         always_ff @(posedge clk) begin
            if (do_push) mem[wptr] <= push_data;
         end

         assign head      = mem[rptr];
         assign not_empty = (cnt != '0);
      end
   endgenerate
endmodule

// File: rtl/spi_bufclient.sv
module spi_bufclient
   import spi_bufclient_pkg::*;
#(
   parameter int unsigned DATA_W      = SPI_BYTE_W,
   parameter int unsigned RX_DEPTH    = 2,
   parameter int unsigned SYNC_STAGES = 2,
   parameter logic [DATA_W-1:0] SHIFT_INIT = '0
)(
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wait_rx,
   input  logic              wr_en,
   input  logic [DATA_W-1:0] wr_data,
   input  logic              rd_en,
   output logic [DATA_W-1:0] rd_data,
   input  logic              clr_done,
   output logic              buf_empty,
   output logic              rx_ready,
   output logic              xfer_done,
   input  logic              sck,
   input  logic              mosi,
   input  logic              ss_n,
   output logic              miso
);
   generate
      if (DATA_W < 2) begin : g_bad_width
         $error("spi_bufclient: DATA_W must be at least 2");
      end
   endgenerate

   spi_pins_t pins_raw, pins_s;
   logic      ss_act;
   logic      byte_done;
   logic [DATA_W-1:0] rx_byte;

   assign pins_raw.sck  = sck;
   assign pins_raw.mosi = mosi;
   assign pins_raw.ss_n = ss_n;

   spi_bc_sync #(
      .W       ($bits(spi_pins_t)),
      .STAGES  (SYNC_STAGES),
      .RST_VAL (PINS_IDLE)
   ) u_sync (
      .clk   (clk),
      .rst_n (rst_n),
      .d     (pins_raw),
      .q     (pins_s)
   );

   assign ss_act = ~pins_s.ss_n;

   // ---------------- transmit holding register ----------------
   logic [DATA_W-1:0] hold_q;
   logic              hold_full;
   logic              primed;     // shifter holds user data not yet sent
   logic              wr_take;
   logic              copy_now;
   logic              load_en;

   assign wr_take  = wr_en & ~hold_full;
   assign copy_now = wait_rx & ~ss_act & hold_full & ~primed;
   assign load_en  = (byte_done & hold_full) | copy_now;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       hold_q <= '0;
      else if (wr_take) hold_q <= wr_data;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       hold_full <= 1'b0;
      else if (wr_take) hold_full <= 1'b1;
      else if (load_en) hold_full <= 1'b0;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                      primed <= 1'b0;
      else if (copy_now)               primed <= 1'b1;
      else if (byte_done || !wait_rx)  primed <= 1'b0;
   end

   spi_bc_serdes #(
      .DATA_W     (DATA_W),
      .SHIFT_INIT (SHIFT_INIT)
   ) u_serdes (
      .clk       (clk),
      .rst_n     (rst_n),
      .sck_s     (pins_s.sck),
      .mosi_s    (pins_s.mosi),
      .ss_act    (ss_act),
      .load_en   (load_en),
      .load_val  (hold_q),
      .miso      (miso),
      .byte_done (byte_done),
      .rx_byte   (rx_byte)
   );

   // ---------------- staggered flag pipeline ----------------
   // boundary -> buf_empty (+1), rx data visible (+2), xfer_done (+3)
   logic              push_q;
   logic [DATA_W-1:0] push_byte_q;
   logic              idle_q, idle_q2;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         push_q      <= 1'b0;
         push_byte_q <= '0;
         idle_q      <= 1'b0;
         idle_q2     <= 1'b0;
      end else begin
         push_q      <= byte_done;
         push_byte_q <= rx_byte;
         idle_q      <= byte_done & ~hold_full;
         idle_q2     <= idle_q;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                  xfer_done <= 1'b0;
      else if (idle_q2)            xfer_done <= 1'b1;
      else if (clr_done || wr_en)  xfer_done <= 1'b0;
   end

   spi_bc_rxfifo #(
      .DATA_W (DATA_W),
      .DEPTH  (RX_DEPTH)
   ) u_rxfifo (
      .clk       (clk),
      .rst_n     (rst_n),
      .push      (push_q),
      .push_data (push_byte_q),
      .pop       (rd_en),
      .head      (rd_data),
      .not_empty (rx_ready)
   );

   assign buf_empty = ~hold_full;
endmodule

// File: rtl/spi_bufclient_chk.sv
module spi_bufclient_chk (
   input logic clk,
   input logic rst_n,
   input logic wr_en,
   input logic rd_en,
   input logic clr_done,
   input logic buf_empty,
   input logic rx_ready,
   input logic xfer_done,
   input logic byte_done,
   input logic ss_act,
   input logic push_q,
   input logic idle_q2
);
   AST_WRITE_FILLS: assert property (@(posedge clk) disable iff (!rst_n)
      (buf_empty && wr_en) |=> !buf_empty);                              // R2

   AST_FULL_KEPT: assert property (@(posedge clk) disable iff (!rst_n)
      (!buf_empty && !byte_done && ss_act) |=> !buf_empty);              // R3

   AST_HANDOVER_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
      (byte_done && !buf_empty) |=> buf_empty);                          // R4

   AST_RX_LAG: assert property (@(posedge clk) disable iff (!rst_n)
      byte_done |=> ##1 rx_ready);                                       // R9

   AST_DONE_AFTER_RX: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(xfer_done) |-> $past(rx_ready));                             // R10

   AST_DONE_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
      ((clr_done || wr_en) && !idle_q2) |=> !xfer_done);                 // R11

   AST_NO_UNDERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
      (!rx_ready && rd_en && !push_q) |=> !rx_ready);                    // R8
endmodule

bind spi_bufclient spi_bufclient_chk u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .wr_en     (wr_en),
   .rd_en     (rd_en),
   .clr_done  (clr_done),
   .buf_empty (buf_empty),
   .rx_ready  (rx_ready),
   .xfer_done (xfer_done),
   .byte_done (byte_done),
   .ss_act    (ss_act),
   .push_q    (push_q),
   .idle_q2   (idle_q2)
);

// File: tb/sim_spi_bufclient.sv
module sim_spi_bufclient;
   localparam int HP = 8;   // SCK half period in system clocks

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       wait_rx = 1'b0;
   logic       wr_en = 1'b0;
   logic [7:0] wr_data = '0;
   logic       rd_en = 1'b0;
   logic [7:0] rd_data;
   logic       clr_done = 1'b0;
   logic       buf_empty, rx_ready, xfer_done;
   logic       sck = 1'b0, mosi = 1'b0, ss_n = 1'b1;
   logic       miso;

   always #4 clk = ~clk;   // 125 MHz

   spi_bufclient u0 (
      .clk(clk), .rst_n(rst_n), .wait_rx(wait_rx), .wr_en(wr_en), .wr_data(wr_data),
      .rd_en(rd_en), .rd_data(rd_data), .clr_done(clr_done), .buf_empty(buf_empty),
      .rx_ready(rx_ready), .xfer_done(xfer_done), .sck(sck), .mosi(mosi),
      .ss_n(ss_n), .miso(miso)
   );

   int nchk = 0, nerr = 0;
   bit finished = 0;

   // reference model state
   logic [7:0] m_sh, m_hold;
   bit         m_full, m_primed, m_done, m_ss_low;
   logic [7:0] rxq [2];
   int         rxn;

   // flag rise monitor
   int  cyc = 0, t_be = 0, t_rx = 0, t_dn = 0;
   logic be_q = 1'b0, rx_q = 1'b0, dn_q = 1'b0;
   always @(negedge clk) begin
      cyc++;
      if (buf_empty && !be_q) t_be = cyc;
      if (rx_ready && !rx_q)  t_rx = cyc;
      if (xfer_done && !dn_q) t_dn = cyc;
      be_q = buf_empty; rx_q = rx_ready; dn_q = xfer_done;
   end

   task automatic tick(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic check(input bit ok, input string tag, input int act, input int exp);
      nchk++;
      if (!ok) begin
         nerr++;
         $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
      end
   endtask

   function automatic bit copy_due();
      return wait_rx && !m_ss_low && m_full && !m_primed;
   endfunction

   task automatic apply_copy();
      if (copy_due()) begin
         m_sh = m_hold; m_full = 0; m_primed = 1;
      end
   endtask

   task automatic do_reset(input bit mode);
      rst_n = 0; ss_n = 1; sck = 0; mosi = 0; wait_rx = mode;
      tick(3);
      rst_n = 1;
      tick(2);
      m_sh = 8'h00; m_hold = 8'h00; m_full = 0; m_primed = 0; m_done = 0;
      m_ss_low = 0; rxn = 0;
   endtask

   task automatic chk_flags(input string tag);
      check(buf_empty == !m_full, {tag, " buf_empty"}, buf_empty, !m_full);
      check(rx_ready == (rxn > 0), {tag, " rx_ready"}, rx_ready, rxn > 0);
      check(xfer_done == m_done, {tag, " xfer_done"}, xfer_done, m_done);
   endtask

   task automatic select();
      ss_n = 0; m_ss_low = 1; tick(HP);
   endtask

   task automatic deselect();
      ss_n = 1; m_ss_low = 0; tick(HP);
      apply_copy();
   endtask

   task automatic host_write(input logic [7:0] d);
      wr_data = d; wr_en = 1; tick(1);
      wr_en = 0; tick(2);
      m_done = 0;
      if (!m_full) begin m_hold = d; m_full = 1; end
      apply_copy();
   endtask

   task automatic host_read(input string tag);
      if (rxn > 0) check(rd_data == rxq[0], {tag, " rd_data"}, rd_data, rxq[0]);
      rd_en = 1; tick(1);
      rd_en = 0; tick(1);
      if (rxn > 0) begin rxq[0] = rxq[1]; rxn--; end
      check(rx_ready == (rxn > 0), {tag, " rx_ready after read"}, rx_ready, rxn > 0);
   endtask

   task automatic pulse_clr();
      clr_done = 1; tick(1);
      clr_done = 0; tick(1);
      m_done = 0;
   endtask

   // mode 0 master: drive MOSI after falling edge, sample MISO before rising
   task automatic xfer_raw(input logic [7:0] mo, output logic [7:0] mi, input int nbits);
      for (int i = 7; i > 7 - nbits; i--) begin
         mosi = mo[i];
         tick(HP);
         mi[i] = miso;
         sck = 1;
         tick(HP);
         sck = 0;
      end
      tick(HP);
   endtask

   task automatic xfer_chk(input logic [7:0] mo, input string tag);
      logic [7:0] got, exp;
      exp = m_sh;
      xfer_raw(mo, got, 8);
      check(got == exp, {tag, " miso byte"}, got, exp);
      if (m_full) begin m_sh = m_hold; m_full = 0; end
      else m_done = 1;
      m_primed = 0;
      if (rxn < 2) begin rxq[rxn] = mo; rxn++; end
      chk_flags(tag);
   endtask

   task automatic random_phase(input bit mode, input int n);
      do_reset(mode);
      for (int i = 0; i < n; i++) begin
         case ($urandom_range(0, 6))
            0, 1:    host_write(8'($urandom));
            2, 3, 4: begin
               if (!m_ss_low) select();
               xfer_chk(8'($urandom), "R6 random transfer");
            end
            5:       host_read("R8 random read");
            default: begin
               if ($urandom_range(0, 1) == 1) begin
                  if (m_ss_low) deselect(); else select();
               end else pulse_clr();
               chk_flags("R11 random flags");
            end
         endcase
      end
   endtask

   initial begin : watchdog
      repeat (200000) @(posedge clk);
      if (!finished) begin
         nchk++; nerr++;
         $display("FAIL watchdog (all requirements) act=%0d exp=%0d", 200000, 0);
         $display("Result: errors=%0d of %0d checks", nerr, nchk);
         $finish;
      end
   end

   initial begin : main
      logic [7:0] got;
      int seed;
      seed = $urandom(32'd20240611);

      // ---------- R1 reset state ----------
      do_reset(1'b0);
      check(buf_empty == 1'b1, "R1 buf_empty", buf_empty, 1);
      check(rx_ready == 1'b0, "R1 rx_ready", rx_ready, 0);
      check(xfer_done == 1'b0, "R1 xfer_done", xfer_done, 0);
      check(miso == 1'b0, "R1 miso", miso, 0);

      // ---------- wait_rx low directed ----------
      select();
      check(miso == 1'b0, "R7 miso msb of zero shifter", miso, 0);
      host_write(8'hA5);
      check(buf_empty == 1'b0, "R2 buf_empty after write", buf_empty, 0);
      host_write(8'h3C);                         // R3 dropped
      t_be = 0; t_rx = 0; t_dn = 0;
      xfer_chk(8'h81, "R4 dummy byte");
      check(t_rx - t_be == 1, "R9 rx_ready one cycle after buf_empty", t_rx - t_be, 1);
      check(t_dn == 0, "R10 no xfer_done when byte loaded", t_dn, 0);
      host_read("R8 first byte");
      t_rx = 0; t_dn = 0;
      xfer_chk(8'h42, "R3 held byte not overwritten");
      check(t_dn - t_rx == 1, "R10 xfer_done one cycle after rx_ready", t_dn - t_rx, 1);
      xfer_chk(8'h17, "R6 repeated byte");
      xfer_chk(8'h99, "R8 byte dropped when full");
      host_read("R8 oldest");
      host_read("R8 second");
      host_read("R8 read on empty");
      pulse_clr();
      chk_flags("R11 clear strobe");
      xfer_chk(8'h5A, "R6 repeat again");
      host_write(8'hC3);
      chk_flags("R11 write clears done");
      xfer_chk(8'h0F, "R7 serial order");
      host_read("R8 drain");
      host_read("R8 drain");
      deselect();
      check(miso == 1'b0, "R7 miso idle when deselected", miso, 0);

      // ---------- R12 abort mid-byte ----------
      select();
      xfer_raw(8'hFF, got, 3);
      ss_n = 1; tick(HP);
      ss_n = 0; tick(HP);
      xfer_raw(8'h6E, got, 8);
      check(rx_ready == 1'b1, "R12 one byte after abort", rx_ready, 1);
      check(rd_data == 8'h6E, "R12 whole byte received", rd_data, 8'h6E);
      rd_en = 1; tick(1); rd_en = 0; tick(1);
      check(rx_ready == 1'b0, "R12 partial byte not stored", rx_ready, 0);

      // ---------- wait_rx high directed ----------
      do_reset(1'b1);
      host_write(8'h43);
      check(buf_empty == 1'b1, "R5 copied to shifter", buf_empty, 1);
      host_write(8'h44);
      check(buf_empty == 1'b0, "R5 second write held", buf_empty, 0);
      host_write(8'h45);                         // dropped
      select();
      xfer_chk(8'h11, "R5 first byte is user data");
      host_write(8'h46);
      xfer_chk(8'h22, "R5 held byte second");
      xfer_chk(8'h33, "R5 third byte");
      xfer_chk(8'h44, "R6 repeat in wait mode");

      // ---------- constrained random, both modes ----------
      random_phase(1'b0, 70);
      random_phase(1'b1, 70);

      finished = 1;
      $display("Result: errors=%0d of %0d checks", nerr, nchk);
      $finish;
   end
endmodule